// File: doc/BRIEF.md
# Sensor Sample Min/Max Alarm Monitor

This block sits behind a free-running converter that scans one temperature sensor, a set of supply sensors and up to seventeen external inputs in turn. Each conversion arrives as a one-cycle valid strobe with a channel number and a 10-bit unsigned code. No request is needed. Whatever the converter delivers is folded into the per-channel state. For every channel the block keeps the most recent code and the lowest and highest codes seen since reset or since the last clear.

Window comparators guard the temperature and supply channels. Each supply channel has its own upper and lower limit, and its alarm follows the latest sample of that channel. The temperature channel has an over-temperature alarm with hysteresis. When that alarm sets, it also latches a power-down request. The request stays asserted until software clears it. A small register port gives synchronous reads of every stored value and of the limit registers. Writes reach the limits and two command addresses.

Top module: `smon_top`

## Requirements
- R1: After reset the alarm outputs and the power-down request are 0, the read data is 0, every minimum register reads 0x3FF and every maximum register reads 0x000. The limit registers hold their defaults: over-temperature 900, rearm 800, each supply upper 700 and each supply lower 300.
- R2: A valid sample on channel c (0 = temperature, 1..2 = supplies, 3..19 = external) replaces that channel's latest value at the clock edge where the strobe is high. A channel number of 20 or above is ignored and changes no stored value and no alarm.
- R3: A sample lowers the channel's minimum when its code is smaller and raises its maximum when its code is larger. The first sample after reset or clear therefore sets both to its code.
- R4: A write to address 0x70 returns the minimum of every channel to 0x3FF and the maximum to 0x000, and leaves the latest values unchanged. A sample in the same cycle is applied on top of the cleared values.
- R5: Supply alarm bit s (channel s+1) is set by a sample of that channel whose code is above its upper limit or below its lower limit. It is cleared by a sample inside the window, with both limits inclusive. Samples on other channels leave it unchanged.
- R6: The over-temperature alarm sets on a temperature sample with code greater than or equal to the over-temperature limit. It stays set until a temperature sample with code strictly below the rearm limit arrives.
- R7: The power-down request is set in the cycle the over-temperature alarm sets, and only then. It stays set until a write to address 0x71. Clearing it while the alarm is still set does not re-raise it until the alarm has rearmed and tripped again.
- R8: Read data appears one clock after the address is presented. Addresses 0x00+c give the latest value of channel c, 0x20+c the minimum and 0x40+c the maximum. Addresses 0x60..0x65 give the limits in the order over-temperature, rearm, supply 0 upper, supply 0 lower, supply 1 upper, supply 1 lower. Every other address reads 0.
- R9: Writes to 0x60..0x65 replace the corresponding limit. Writes to the sample area (0x00..0x5F) are ignored.
- R10: A read of a channel's address in the same cycle as a sample for that channel returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 5 | Channel number of the sample |
| smp_code_i | input | 10 | Unsigned conversion code |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address for read and write |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Registered read data |
| alarm_supply_o | output | 2 | Supply window alarms, bit s for channel s+1 |
| alarm_temp_o | output | 1 | Over-temperature alarm |
| shutdown_req_o | output | 1 | Latched power-down request |

## Verification
Min/max tracking is driven with a channel whose codes go up and down out of order. This separates true running extremes from "first value" or "last value" behaviour. A single-sample channel shows that the first sample sets both extremes.

The window comparators are tried at codes exactly on each limit and at one code beyond it. Samples on other channels are interleaved to show that alarms are per channel. The temperature path is driven through a trip, a hold above rearm, a clear while still hot, a code equal to the rearm limit, a code just below it and a second trip. This tells hysteresis apart from a plain comparator and a latched request apart from a level.

A read that coincides with a sample, a clear that coincides with a sample, and an out-of-range channel cover the ordering cases.

// File: rtl/smon_pkg.sv
package smon_pkg;
    localparam int unsigned DATA_W  = 10;
    localparam int unsigned NUM_SUP = 2;
    localparam int unsigned NUM_EXT = 17;
    localparam int unsigned NUM_CH  = 1 + NUM_SUP + NUM_EXT;
    localparam int unsigned CH_W    = $clog2(NUM_CH + 1);
    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned NUM_LIM = 2 + 2 * NUM_SUP;

    localparam int unsigned TEMP_CH = 0;
    localparam int unsigned LIM_OT  = 0;
    localparam int unsigned LIM_RA  = 1;

    // region select: addr[ADDR_W-1:ADDR_W-2]
    localparam logic [1:0] RGN_LAST = 2'd0;
    localparam logic [1:0] RGN_MIN  = 2'd1;
    localparam logic [1:0] RGN_MAX  = 2'd2;
    localparam logic [1:0] RGN_CTRL = 2'd3;

    localparam logic [ADDR_W-1:0] ADDR_CLR_MM = 7'h70;
    localparam logic [ADDR_W-1:0] ADDR_CLR_SD = 7'h71;

    function automatic logic [DATA_W-1:0] lim_default(input int unsigned idx);
        if (idx == LIM_OT)       return DATA_W'(900);
        else if (idx == LIM_RA)  return DATA_W'(800);
        else if (idx[0] == 1'b0) return DATA_W'(700);
        else                     return DATA_W'(300);
    endfunction
endpackage

// File: rtl/smon_store.sv
module smon_store
    import smon_pkg::*;
#(
    parameter int unsigned N  = NUM_CH,
    parameter int unsigned W  = DATA_W,
    parameter int unsigned CW = CH_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                smp_valid_i,
    input  logic [CW-1:0]       smp_chan_i,
    input  logic [W-1:0]        smp_code_i,
    input  logic                clr_i,
    output logic [N-1:0][W-1:0] last_o,
    output logic [N-1:0][W-1:0] min_o,
    output logic [N-1:0][W-1:0] max_o
);
    typedef struct packed {
        logic [N-1:0][W-1:0] last;
        logic [N-1:0][W-1:0] lo;
        logic [N-1:0][W-1:0] hi;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            for (int c = 0; c < N; c++) begin
                st_d.lo[c] = '1;
                st_d.hi[c] = '0;
            end
        end
        if (smp_valid_i) begin
            for (int c = 0; c < N; c++) begin
                if (smp_chan_i == CW'(c)) begin
                    st_d.last[c] = smp_code_i;
                    if (smp_code_i < st_d.lo[c]) st_d.lo[c] = smp_code_i;
                    if (smp_code_i > st_d.hi[c]) st_d.hi[c] = smp_code_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int c = 0; c < N; c++) begin
                st_q.last[c] <= '0;
                st_q.lo[c]   <= '1;
                st_q.hi[c]   <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = st_q.last;
    assign min_o  = st_q.lo;
    assign max_o  = st_q.hi;

    for (genvar c = 0; c < N; c++) begin : g_chk
        assert_latest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (smp_valid_i && smp_chan_i == CW'(c)) |=> (st_q.last[c] == $past(smp_code_i)));
        assert_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.lo[c] <= st_q.hi[c]) || (st_q.lo[c] == '1 && st_q.hi[c] == '0));
        assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !smp_valid_i) |=> (st_q.lo[c] == '1 && st_q.hi[c] == '0));
    end
endmodule

// File: rtl/smon_limits.sv
module smon_limits
    import smon_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned CW = CH_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NS = NUM_SUP
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        smp_valid_i,
    input  logic [CW-1:0]               smp_chan_i,
    input  logic [W-1:0]                smp_code_i,
    input  logic                        reg_wr_i,
    input  logic [AW-1:0]               reg_addr_i,
    input  logic [W-1:0]                reg_wdata_i,
    output logic [2+2*NS-1:0][W-1:0]    lim_o,
    output logic [NS-1:0]               sup_alm_o,
    output logic                        temp_alm_o,
    output logic                        sd_req_o
);
    localparam int unsigned NL = 2 + 2 * NS;

    typedef struct packed {
        logic [NL-1:0][W-1:0] lim;
        logic [NS-1:0]        sup;
        logic                 temp;
        logic                 sd;
    } lim_st_t;

    lim_st_t st_d, st_q;

    logic temp_smp;
    logic sd_clr;
    assign temp_smp = smp_valid_i && (smp_chan_i == CW'(TEMP_CH));
    assign sd_clr   = reg_wr_i && (reg_addr_i == ADDR_CLR_SD);

    always_comb begin
        st_d = st_q;
        // limit register writes
        if (reg_wr_i && reg_addr_i[AW-1:AW-2] == RGN_CTRL && !reg_addr_i[AW-3]) begin
            for (int l = 0; l < NL; l++) begin
                if (reg_addr_i[AW-4:0] == (AW-3)'(l)) st_d.lim[l] = reg_wdata_i;
            end
        end
        // supply windows, inclusive limits
        for (int s = 0; s < NS; s++) begin
            if (smp_valid_i && smp_chan_i == CW'(s + 1)) begin
                st_d.sup[s] = (smp_code_i > st_q.lim[2 + 2*s]) ||
                              (smp_code_i < st_q.lim[3 + 2*s]);
            end
        end
        // over-temperature with hysteresis and latched request
        if (sd_clr) st_d.sd = 1'b0;
        if (temp_smp) begin
            if (!st_q.temp && smp_code_i >= st_q.lim[LIM_OT]) begin
                st_d.temp = 1'b1;
                st_d.sd   = 1'b1;
            end else if (st_q.temp && smp_code_i < st_q.lim[LIM_RA]) begin
                st_d.temp = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int l = 0; l < NL; l++) st_q.lim[l] <= lim_default(l);
            st_q.sup  <= '0;
            st_q.temp <= 1'b0;
            st_q.sd   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lim_o      = st_q.lim;
    assign sup_alm_o  = st_q.sup;
    assign temp_alm_o = st_q.temp;
    assign sd_req_o   = st_q.sd;

    for (genvar s = 0; s < NS; s++) begin : g_sup_chk
        assert_supply_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(st_q.sup[s]) |-> $past(smp_valid_i && smp_chan_i == CW'(s + 1)));
        assert_supply_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(smp_valid_i && smp_chan_i == CW'(s + 1)) |=> $stable(st_q.sup[s]));
    end

    assert_temp_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.temp) |-> $past(temp_smp && smp_code_i < st_q.lim[LIM_RA]));
    assert_sd_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.sd) |-> $rose(st_q.temp));
    assert_sd_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.sd) |-> $past(sd_clr));
endmodule

// File: rtl/smon_readmux.sv
module smon_readmux
    import smon_pkg::*;
#(
    parameter int unsigned N  = NUM_CH,
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NL = NUM_LIM
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [AW-1:0]        reg_addr_i,
    input  logic [N-1:0][W-1:0]  last_i,
    input  logic [N-1:0][W-1:0]  min_i,
    input  logic [N-1:0][W-1:0]  max_i,
    input  logic [NL-1:0][W-1:0] lim_i,
    output logic [W-1:0]         rdata_o
);
    localparam int unsigned IW = AW - 2;

    logic [W-1:0] rdata_d, rdata_q;
    logic [1:0]   rgn;
    logic [IW-1:0] idx;

    assign rgn = reg_addr_i[AW-1:AW-2];
    assign idx = reg_addr_i[IW-1:0];

    always_comb begin
        rdata_d = '0;
        for (int c = 0; c < N; c++) begin
            if (idx == IW'(c)) begin
                case (rgn)
                    RGN_LAST: rdata_d = last_i[c];
                    RGN_MIN:  rdata_d = min_i[c];
                    RGN_MAX:  rdata_d = max_i[c];
                    default:  ;
                endcase
            end
        end
        if (rgn == RGN_CTRL) begin
            for (int l = 0; l < NL; l++) begin
                if (idx == IW'(l)) rdata_d = lim_i[l];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    assert_unmapped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rgn == RGN_CTRL && idx >= IW'(NL)) |=> (rdata_q == '0));
endmodule

// File: rtl/smon_top.sv
module smon_top
    import smon_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               smp_valid_i,
    input  logic [CH_W-1:0]    smp_chan_i,
    input  logic [DATA_W-1:0]  smp_code_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NUM_SUP-1:0] alarm_supply_o,
    output logic               alarm_temp_o,
    output logic               shutdown_req_o
);
    logic [NUM_CH-1:0][DATA_W-1:0]  last_w, min_w, max_w;
    logic [NUM_LIM-1:0][DATA_W-1:0] lim_w;
    logic                           clr_mm;

    assign clr_mm = reg_wr_i && (reg_addr_i == ADDR_CLR_MM);

    smon_store #(.N(NUM_CH), .W(DATA_W), .CW(CH_W)) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .smp_valid_i (smp_valid_i),
        .smp_chan_i  (smp_chan_i),
        .smp_code_i  (smp_code_i),
        .clr_i       (clr_mm),
        .last_o      (last_w),
        .min_o       (min_w),
        .max_o       (max_w)
    );

    smon_limits #(.W(DATA_W), .CW(CH_W), .AW(ADDR_W), .NS(NUM_SUP)) u_limits (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .smp_valid_i (smp_valid_i),
        .smp_chan_i  (smp_chan_i),
        .smp_code_i  (smp_code_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .lim_o       (lim_w),
        .sup_alm_o   (alarm_supply_o),
        .temp_alm_o  (alarm_temp_o),
        .sd_req_o    (shutdown_req_o)
    );

    smon_readmux #(.N(NUM_CH), .W(DATA_W), .AW(ADDR_W), .NL(NUM_LIM)) u_rmux (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .reg_addr_i (reg_addr_i),
        .last_i     (last_w),
        .min_i      (min_w),
        .max_i      (max_w),
        .lim_i      (lim_w),
        .rdata_o    (reg_rdata_o)
    );

    assert_reset_R1: assert property (@(posedge clk_i)
        $past(!rst_ni) |-> (!shutdown_req_o && !alarm_temp_o && alarm_supply_o == '0));
    assert_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_valid_i && smp_chan_i >= CH_W'(NUM_CH) && !reg_wr_i) |=>
        ($stable(alarm_supply_o) && $stable(alarm_temp_o) && $stable(shutdown_req_o)));
endmodule

// File: tb/test_smon_top.sv
module test_smon_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [4:0] smp_chan = '0;
    logic [9:0] smp_code = '0;
    logic       reg_wr = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic [1:0] alarm_supply;
    logic       alarm_temp;
    logic       shutdown_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    smon_top i_smon_top (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .smp_valid_i    (smp_valid),
        .smp_chan_i     (smp_chan),
        .smp_code_i     (smp_code),
        .reg_wr_i       (reg_wr),
        .reg_addr_i     (reg_addr),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .alarm_supply_o (alarm_supply),
        .alarm_temp_o   (alarm_temp),
        .shutdown_req_o (shutdown_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input int ch, input int code);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 5'(ch); smp_code = 10'(code);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'(addr); reg_wdata = 10'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        reg_addr = 7'(addr);
        @(negedge clk);
        data = int'(reg_rdata);
    endtask

    task automatic t_reset();
        int v;
        check("R1 rdata", int'(reg_rdata), 0);
        check("R1 alarms", int'({alarm_supply, alarm_temp, shutdown_req}), 0);
        rd(7'h24, v); check("R1 min ch4", v, 1023);
        rd(7'h44, v); check("R1 max ch4", v, 0);
        rd(7'h60, v); check("R1 ot limit", v, 900);
        rd(7'h61, v); check("R1 rearm limit", v, 800);
        rd(7'h63, v); check("R1 sup0 lower", v, 300);
        rd(7'h64, v); check("R1 sup1 upper", v, 700);
    endtask

    task automatic t_minmax();
        int v;
        sample(5, 500); sample(5, 200); sample(5, 800); sample(5, 300);
        rd(7'h05, v); check("R2 latest ch5", v, 300);
        rd(7'h25, v); check("R3 min ch5", v, 200);
        rd(7'h45, v); check("R3 max ch5", v, 800);
        sample(19, 7);
        rd(7'h13, v); check("R2 latest ch19", v, 7);
        rd(7'h33, v); check("R3 first min ch19", v, 7);
        rd(7'h53, v); check("R3 first max ch19", v, 7);
        sample(20, 999); sample(21, 0);
        rd(7'h04, v); check("R2 out-of-range ch4 latest", v, 0);
        rd(7'h05, v); check("R2 out-of-range ch5 latest", v, 300);
        rd(7'h25, v); check("R2 out-of-range ch5 min", v, 200);
        check("R2 out-of-range alarms", int'({alarm_supply, alarm_temp}), 0);
    endtask

    task automatic t_clear();
        int v;
        wr(7'h70, 0);
        rd(7'h25, v); check("R4 min cleared", v, 1023);
        rd(7'h45, v); check("R4 max cleared", v, 0);
        rd(7'h05, v); check("R4 latest kept", v, 300);
        sample(5, 400);
        rd(7'h25, v); check("R4 min after clear", v, 400);
        rd(7'h45, v); check("R4 max after clear", v, 400);
        // clear and sample together
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'h70;
        smp_valid = 1'b1; smp_chan = 5'd5; smp_code = 10'd600;
        @(negedge clk);
        reg_wr = 1'b0; smp_valid = 1'b0;
        rd(7'h25, v); check("R4 coincident min", v, 600);
        rd(7'h45, v); check("R4 coincident max", v, 600);
    endtask

    task automatic t_supply();
        sample(1, 701); check("R5 sup0 above", int'(alarm_supply), 1);
        sample(2, 299); check("R5 sup1 below", int'(alarm_supply), 3);
        sample(3, 1000); check("R5 other channel", int'(alarm_supply), 3);
        sample(0, 100); check("R5 temp channel", int'(alarm_supply), 3);
        sample(1, 700); check("R5 sup0 upper inclusive", int'(alarm_supply), 2);
        sample(2, 300); check("R5 sup1 lower inclusive", int'(alarm_supply), 0);
    endtask

    task automatic t_temp();
        sample(0, 899);
        check("R6 below limit", int'(alarm_temp), 0);
        check("R7 no request", int'(shutdown_req), 0);
        sample(0, 900);
        check("R6 trip at limit", int'(alarm_temp), 1);
        check("R7 request set", int'(shutdown_req), 1);
        sample(0, 850);
        check("R6 hold above rearm", int'(alarm_temp), 1);
        check("R7 held", int'(shutdown_req), 1);
        wr(7'h71, 0);
        check("R7 cleared", int'(shutdown_req), 0);
        check("R6 alarm after clear", int'(alarm_temp), 1);
        sample(0, 950);
        check("R7 no retrigger while hot", int'(shutdown_req), 0);
        sample(0, 800);
        check("R6 rearm is strict", int'(alarm_temp), 1);
        sample(0, 799);
        check("R6 rearmed", int'(alarm_temp), 0);
        check("R7 stays clear", int'(shutdown_req), 0);
        sample(0, 901);
        check("R6 second trip", int'(alarm_temp), 1);
        check("R7 second request", int'(shutdown_req), 1);
        sample(0, 100);
        check("R7 latched after cool", int'(shutdown_req), 1);
        wr(7'h71, 0);
        check("R7 final clear", int'(shutdown_req), 0);
    endtask

    task automatic t_limits();
        int v;
        wr(7'h60, 500);
        rd(7'h60, v); check("R9 ot limit write", v, 500);
        wr(7'h61, 450);
        rd(7'h61, v); check("R9 rearm limit write", v, 450);
        wr(7'h05, 123);
        rd(7'h05, v); check("R9 sample area write ignored", v, 600);
        wr(7'h45, 5);
        rd(7'h45, v); check("R9 max area write ignored", v, 600);
        sample(0, 500);
        check("R9 new limit trips", int'(alarm_temp), 1);
        sample(0, 449);
        check("R9 new rearm", int'(alarm_temp), 0);
        wr(7'h71, 0);
        wr(7'h62, 100);
        sample(1, 101);
        check("R9 supply limit write", int'(alarm_supply), 1);
    endtask

    task automatic t_reads();
        int v;
        rd(7'h7F, v); check("R8 unmapped 0x7F", v, 0);
        rd(7'h66, v); check("R8 unmapped 0x66", v, 0);
        rd(7'h14, v); check("R8 unmapped 0x14", v, 0);
        rd(7'h65, v); check("R8 sup1 lower", v, 300);
        // address presented, data one clock later
        @(negedge clk);
        reg_addr = 7'h13;
        @(posedge clk); #1;
        check("R8 one-clock latency", int'(reg_rdata), 7);
        // read coincident with a sample of the same channel
        @(negedge clk);
        reg_addr = 7'h13;
        smp_valid = 1'b1; smp_chan = 5'd19; smp_code = 10'd77;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R10 old value", int'(reg_rdata), 7);
        @(negedge clk);
        check("R10 new value next", int'(reg_rdata), 77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_minmax();
        t_clear();
        t_supply();
        t_temp();
        t_limits();
        t_reads();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule